// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Interrupt Sensing

This block is an eight-pin general-purpose I/O port driven by a single-cycle register bus. Software chooses, for each pin, whether it drives (output enable), whether its digital input path is live, and whether it is flagged for analog use. Data accesses carry a pin mask in the address, so one read or write touches only the selected pins and no read-modify-write sequence is needed.

Each pin has its own interrupt sensing. A pin can latch an event on a rising edge, a falling edge or either edge. It can instead report a level while its input is high, or while it is low. Latched edge events stay set until software writes a one to the clear register. A per-pin mask decides which recorded events reach the combined interrupt line. A second per-pin enable lets a newly raised, unmasked event emit a one-cycle ADC start pulse. Inputs pass through a synchronizer before any sensing.

Address bit 10 selects the space. When it is 0 the access goes to the data window and address bits [9:2] are the pin mask. When it is 1 the access goes to configuration, and address bits [5:2] give the register index. The index values are:

| Index | Register | Meaning |
|-------|----------|---------|
| 0 | direction | 1 = output |
| 1 | digital enable | 1 = digital input path on |
| 2 | analog flag | 1 = pin marked analog |
| 3 | sense | 1 = level, 0 = edge |
| 4 | both-edge | 1 = either edge |
| 5 | polarity | 1 = rising or high, 0 = falling or low |
| 6 | interrupt mask | 1 = event reaches `irq` |
| 7 | raw status | read only |
| 8 | masked status | read only |
| 9 | clear | write one to clear, reads zero |
| 10 | ADC enable | 1 = pin may fire `adc_trig` |

Top module: `gpio_sense_port`

## Requirements
- R1: After reset every register is zero. As a result `pin_oe`, `pin_out`, `pin_ana`, `irq` and `adc_trig` are all 0, and every configuration register reads back 0.
- R2: `pin_oe` equals the direction register (index 0), and `pin_out` equals the output data register.
- R3: A write to the data window sets only the output bits whose address-mask bit (address bits [9:2]) is 1. All other output bits keep their value, and without such a write the output data does not change.
- R4: A read of the data window returns 0 in every bit whose mask bit is 0. A selected output pin returns its output data bit. A selected input pin returns its synchronized input.
- R5: The analog flag register (index 2) drives `pin_ana`. For a pin whose digital enable bit (index 1) is 0, the pin reads 0 as an input and raises no edge event.
- R6: In edge mode a detected event sets the pin's raw status bit (index 7), and the bit stays set until a one is written to that bit of the clear register (index 9). Writing a one to any other bit of the clear register leaves it set.
- R7: With sense = 0, polarity = 1 and both-edge = 0, only a rising edge sets the raw bit. With polarity = 0, only a falling edge sets it. With both-edge = 1, either edge sets it.
- R8: With sense = 1, the raw bit follows the synchronized input. It is 1 while the input is high when polarity = 1, and 1 while the input is low when polarity = 0.
- R9: Masked status (index 8) is the raw status ANDed with the mask (index 6), and `irq` is 1 exactly when some masked status bit is 1. Masked-off events are still recorded in the raw status.
- R10: `adc_trig` pulses high for exactly one cycle when a masked status bit whose ADC enable bit (index 10) is 1 goes from 0 to 1. It never pulses while the ADC enable register is zero.
- R11: Data writes on consecutive cycles change `pin_out` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address: space select, mask or index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |
| pin_ana | output | 8 | Pin analog flags |
| irq | output | 1 | Combined port interrupt |
| adc_trig | output | 1 | One-cycle ADC start pulse |

## Verification
The bench builds the port with its default eight pins and a two-stage synchronizer. This keeps the mask space small enough to sweep completely. All 256 address masks are driven through both masked writes and masked reads, so every combination of selected and untouched pins is compared with arithmetic predictions. All five sensing modes are then applied to each of the eight pins, one at a time, which shows that every pin cell decodes the polarity and both-edge bits correctly and that `irq` follows only the masked pin.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned PINS   = 8;
    localparam int unsigned IDX_W  = 4;
    localparam int unsigned ADDR_W = PINS + 3;

    typedef logic [PINS-1:0] pinvec_t;

    typedef enum logic [IDX_W-1:0] {
        REG_DIR   = 4'd0,
        REG_DEN   = 4'd1,
        REG_AMODE = 4'd2,
        REG_SENSE = 4'd3,
        REG_BOTH  = 4'd4,
        REG_POL   = 4'd5,
        REG_IMASK = 4'd6,
        REG_RAW   = 4'd7,
        REG_MIS   = 4'd8,
        REG_ICLR  = 4'd9,
        REG_ADCEN = 4'd10
    } reg_idx_e;

    typedef struct packed {
        pinvec_t dir;
        pinvec_t den;
        pinvec_t amode;
        pinvec_t sense;
        pinvec_t both;
        pinvec_t pol;
        pinvec_t imask;
        pinvec_t adcen;
    } port_cfg_t;

    function automatic logic is_cfg(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1];
    endfunction

    function automatic pinvec_t addr_mask(input logic [ADDR_W-1:0] a);
        return a[PINS+1:2];
    endfunction

    function automatic reg_idx_e addr_idx(input logic [ADDR_W-1:0] a);
        return reg_idx_e'(a[IDX_W+1:2]);
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  pinvec_t             bus_wdata,
    input  pinvec_t             din_sync,
    input  pinvec_t             raw,
    input  pinvec_t             mis,
    output port_cfg_t           cfg,
    output pinvec_t             dout,
    output pinvec_t             clr,
    output pinvec_t             bus_rdata
);

    logic     wr_en;
    pinvec_t  amask;
    reg_idx_e idx;

    assign wr_en = bus_sel && bus_wr;
    assign amask = addr_mask(bus_addr);
    assign idx   = addr_idx(bus_addr);
    assign clr   = (wr_en && is_cfg(bus_addr) && idx == REG_ICLR) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            dout <= '0;
        end else if (wr_en) begin
            if (!is_cfg(bus_addr)) begin
                dout <= (dout & ~amask) | (bus_wdata & amask);
            end else begin
                case (idx)
                    REG_DIR:   cfg.dir   <= bus_wdata;
                    REG_DEN:   cfg.den   <= bus_wdata;
                    REG_AMODE: cfg.amode <= bus_wdata;
                    REG_SENSE: cfg.sense <= bus_wdata;
                    REG_BOTH:  cfg.both  <= bus_wdata;
                    REG_POL:   cfg.pol   <= bus_wdata;
                    REG_IMASK: cfg.imask <= bus_wdata;
                    REG_ADCEN: cfg.adcen <= bus_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!is_cfg(bus_addr)) begin
            bus_rdata = ((cfg.dir & dout) | (~cfg.dir & din_sync)) & amask;
        end else begin
            case (idx)
                REG_DIR:   bus_rdata = cfg.dir;
                REG_DEN:   bus_rdata = cfg.den;
                REG_AMODE: bus_rdata = cfg.amode;
                REG_SENSE: bus_rdata = cfg.sense;
                REG_BOTH:  bus_rdata = cfg.both;
                REG_POL:   bus_rdata = cfg.pol;
                REG_IMASK: bus_rdata = cfg.imask;
                REG_RAW:   bus_rdata = raw;
                REG_MIS:   bus_rdata = mis;
                REG_ADCEN: bus_rdata = cfg.adcen;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge
    import gpio_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t pin_in,
    input  pinvec_t den,
    output pinvec_t sync,
    output pinvec_t rise,
    output pinvec_t fall
);

    pinvec_t chain [STAGES];
    pinvec_t prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= pin_in & den;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[k] <= '0;
            else     chain[k] <= chain[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= chain[STAGES-1];
    end

    assign sync = chain[STAGES-1];
    assign rise = sync & ~prev & den;
    assign fall = ~sync & prev & den;

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
    input  logic clk,
    input  logic rst,
    input  logic sense,
    input  logic both,
    input  logic pol,
    input  logic den,
    input  logic sync,
    input  logic rise,
    input  logic fall,
    input  logic clr,
    output logic latched,
    output logic raw
);

    logic evt;

    assign evt = ~sense & (both ? (rise | fall) : (pol ? rise : fall));

    always_ff @(posedge clk) begin
        if (rst) latched <= 1'b0;
        else     latched <= (latched & ~clr) | evt;
    end

    assign raw = sense ? (den & (pol ? sync : ~sync)) : latched;

endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
    import gpio_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_ana,
    output logic              irq,
    output logic              adc_trig
);

    port_cfg_t cfg;
    pinvec_t   dout, clr, sync, rise, fall;
    pinvec_t   raw, mis, edge_latch, trig_src, trig_q;

    gpio_regfile u_regs (
        .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
        .din_sync(sync), .raw, .mis, .cfg, .dout, .clr, .bus_rdata
    );

    gpio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk, .rst, .pin_in, .den(cfg.den), .sync, .rise, .fall
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        gpio_irq_cell u_cell (
            .clk, .rst,
            .sense(cfg.sense[i]), .both(cfg.both[i]), .pol(cfg.pol[i]),
            .den(cfg.den[i]), .sync(sync[i]), .rise(rise[i]), .fall(fall[i]),
            .clr(clr[i]), .latched(edge_latch[i]), .raw(raw[i])
        );
    end

    assign mis      = raw & cfg.imask;
    assign trig_src = mis & cfg.adcen;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= '0;
        else     trig_q <= trig_src;
    end

    assign irq      = |mis;
    assign adc_trig = |(trig_src & ~trig_q);
    assign pin_out  = dout;
    assign pin_oe   = cfg.dir;
    assign pin_ana  = cfg.amode;

endmodule

// File: rtl/gpio_sense_port_chk.sv
module gpio_sense_port_chk
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   imask,
    input logic [PINS-1:0]   adcen,
    input logic [PINS-1:0]   edge_latch,
    input logic              irq,
    input logic              adc_trig
);

    logic data_wr, data_rd, clr_wr;
    assign data_wr = bus_sel && bus_wr && !is_cfg(bus_addr);
    assign data_rd = bus_sel && !bus_wr && !is_cfg(bus_addr);
    assign clr_wr  = bus_sel && bus_wr && is_cfg(bus_addr) && addr_idx(bus_addr) == REG_ICLR
                     && bus_wdata != '0;

    AST_WR_KEEPS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (((pin_out ^ $past(pin_out)) & ~$past(addr_mask(bus_addr))) == '0)); // R3
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !data_wr |=> $stable(pin_out)); // R3
    AST_RD_MASKED_ZERO: assert property (@(posedge clk) disable iff (rst)
        data_rd |-> ((bus_rdata & ~addr_mask(bus_addr)) == '0)); // R4
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> (($past(edge_latch) & ~edge_latch) == '0)); // R6
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        (imask == '0) |-> !irq); // R9
    AST_ADC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        adc_trig |-> (adcen != '0)); // R10

endmodule

bind gpio_sense_port gpio_sense_port_chk u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .imask(cfg.imask), .adcen(cfg.adcen), .edge_latch(edge_latch),
    .irq(irq), .adc_trig(adc_trig)
);

// File: tb/tb_gpio_sense_port.sv
module tb_gpio_sense_port;

    localparam int C_DIR = 0, C_DEN = 1, C_AMODE = 2, C_SENSE = 3, C_BOTH = 4,
                   C_POL = 5, C_IMASK = 6, C_RAW = 7, C_MIS = 8, C_CLR = 9, C_ADCEN = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic [7:0]  pin_in = '0, pin_out, pin_oe, pin_ana;
    logic        irq, adc_trig;

    int checks = 0, errors = 0, trig_cnt = 0;

    always #5 clk = ~clk;

    gpio_sense_port dut (
        .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .pin_in, .pin_out, .pin_oe, .pin_ana, .irq, .adc_trig
    );

    always @(negedge clk) if (adc_trig) trig_cnt++;

    function automatic logic [10:0] cfg_a(input int idx);
        return 11'h400 | 11'(idx << 2);
    endfunction

    function automatic logic [10:0] dat_a(input logic [7:0] m);
        return {1'b0, m, 2'b00};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [7:0] d, expo;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 0);
        check("R1 pin_out", pin_out, 0);
        check("R1 pin_ana", pin_ana, 0);
        check("R1 irq", irq, 0);
        check("R1 adc_trig", adc_trig, 0);
        for (int i = 0; i <= C_ADCEN; i++) begin
            rd(cfg_a(i), d);
            check("R1 cfg readback", d, 0);
        end

        // R2 direction
        wr(cfg_a(C_DIR), 8'h3C);
        check("R2 pin_oe", pin_oe, 8'h3C);

        // R3 / R4 sweep over every mask
        wr(cfg_a(C_DIR), 8'hFF);
        expo = 8'h00;
        for (int m = 0; m < 256; m++) begin
            logic [7:0] pat;
            pat  = 8'((m * 37 + 11) & 255);
            expo = (expo & ~8'(m)) | (pat & 8'(m));
            wr(dat_a(8'(m)), pat);
            check("R3 masked write", pin_out, expo);
            check("R2 pin_out", pin_out, expo);
            rd(dat_a(~8'(m)), d);
            check("R4 masked read", d, expo & ~8'(m));
        end

        // R4 / R5 inputs, pin 7 digital path disabled
        wr(cfg_a(C_DIR), 8'h0F);
        wr(cfg_a(C_DEN), 8'h7F);
        pin_in = 8'hFF;
        cyc(4);
        rd(dat_a(8'hFF), d);
        check("R4 mixed read", d, (expo & 8'h0F) | 8'h70);
        rd(dat_a(8'h80), d);
        check("R5 disabled input reads zero", d, 0);
        wr(cfg_a(C_AMODE), 8'hA5);
        check("R5 pin_ana", pin_ana, 8'hA5);
        wr(cfg_a(C_POL), 8'hFF);
        wr(cfg_a(C_CLR), 8'hFF);
        pin_in = 8'h00; cyc(4);
        wr(cfg_a(C_CLR), 8'hFF);
        pin_in = 8'h80; cyc(4);
        rd(cfg_a(C_RAW), d);
        check("R5 disabled pin no event", d[7], 0);

        // R7 / R8 / R9 every mode on every pin
        wr(cfg_a(C_DIR), 8'h00);
        wr(cfg_a(C_DEN), 8'hFF);
        for (int p = 0; p < 8; p++) begin
            for (int mode = 0; mode < 5; mode++) begin
                logic er, ef;
                string tag;
                tag = (mode >= 3) ? "R8" : "R7";
                er  = (mode == 0) || (mode == 2) || (mode == 3);
                ef  = (mode == 1) || (mode == 2) || (mode == 4);
                pin_in = 8'h00;
                wr(cfg_a(C_IMASK), 8'(1 << p));
                wr(cfg_a(C_SENSE), (mode >= 3) ? 8'hFF : 8'h00);
                wr(cfg_a(C_BOTH), (mode == 2) ? 8'hFF : 8'h00);
                wr(cfg_a(C_POL), (mode == 0 || mode == 3) ? 8'hFF : 8'h00);
                cyc(4);
                wr(cfg_a(C_CLR), 8'hFF);
                pin_in[p] = 1'b1; cyc(4);
                rd(cfg_a(C_RAW), d);
                check({tag, " raw after rise"}, d[p], er);
                check("R9 irq after rise", irq, er);
                wr(cfg_a(C_CLR), 8'hFF);
                pin_in[p] = 1'b0; cyc(4);
                rd(cfg_a(C_RAW), d);
                check({tag, " raw after fall"}, d[p], ef);
                rd(cfg_a(C_MIS), d);
                check("R9 masked status", d, ef ? 8'(1 << p) : 8'h00);
                check("R9 irq after fall", irq, ef);
            end
        end

        // R6 sticky edge and selective clear, rising mode on pin 2
        wr(cfg_a(C_SENSE), 8'h00);
        wr(cfg_a(C_BOTH), 8'h00);
        wr(cfg_a(C_POL), 8'hFF);
        wr(cfg_a(C_CLR), 8'hFF);
        pin_in = 8'h04; cyc(4);
        pin_in = 8'h00; cyc(10);
        rd(cfg_a(C_RAW), d);
        check("R6 sticky", d[2], 1);
        wr(cfg_a(C_CLR), 8'h01);
        rd(cfg_a(C_RAW), d);
        check("R6 other clear bit", d[2], 1);
        wr(cfg_a(C_CLR), 8'h04);
        rd(cfg_a(C_RAW), d);
        check("R6 cleared", d[2], 0);

        // R9 masked-off event recorded, irq follows mask
        wr(cfg_a(C_IMASK), 8'h00);
        pin_in = 8'h01; cyc(4);
        rd(cfg_a(C_RAW), d);
        check("R9 raw recorded", d[0], 1);
        check("R9 irq masked off", irq, 0);
        wr(cfg_a(C_IMASK), 8'h01);
        check("R9 irq after unmask", irq, 1);

        // R10 ADC trigger
        pin_in = 8'h00; cyc(4);
        wr(cfg_a(C_CLR), 8'hFF);
        wr(cfg_a(C_ADCEN), 8'h01);
        cyc(2);
        trig_cnt = 0;
        pin_in = 8'h01; cyc(6);
        check("R10 one pulse", trig_cnt, 1);
        wr(cfg_a(C_ADCEN), 8'h00);
        pin_in = 8'h00; cyc(4);
        wr(cfg_a(C_CLR), 8'hFF);
        cyc(2);
        trig_cnt = 0;
        pin_in = 8'h01; cyc(6);
        check("R10 no pulse when disabled", trig_cnt, 0);

        // R11 back-to-back writes
        wr(cfg_a(C_DIR), 8'hFF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = dat_a(8'hFF);
        for (int k = 0; k < 6; k++) begin
            bus_wdata = k[0] ? 8'hAA : 8'h55;
            @(negedge clk);
            check("R11 toggle each cycle", pin_out, k[0] ? 8'hAA : 8'h55);
        end
        bus_sel = 1'b0; bus_wr = 1'b0;

        cyc(2);
        finish_run();
    end

endmodule